// File: doc/BRIEF.md
# Two-Level Prioritised Interrupt Controller

This block gathers five interrupt sources for a small CPU core: two external pins, two timer overflows and one serial port. Each source has its own enable bit, and a global enable sits above all of them. Each source also has a priority bit that places it in the high or the low level. The block picks one request and raises a registered request line to the CPU. With it comes the 16-bit entry address of the chosen service routine.

The block keeps one in-service marker for each level, and these markers enforce nesting. A high-level request may interrupt a low-level routine. A request at the level already in service waits until the CPU signals the end of that routine. When several requests at one level are pending together, a fixed polling order decides. External pins can latch a falling edge, or they can follow a low level. Edge flags and timer flags clear when the CPU acknowledges the vector. The serial request is the OR of the receive and transmit flags, and the block never clears it.

Top module: `irq_ctrl_top`

## Requirements
- R1: While `glb_en` is 0, `irq_out` stays 0 whatever the source enables and pending flags are.
- R2: Source i can raise `irq_out` only while `en_mask[i]` is 1. The source indices are: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4.
- R3: `prio_hi[i]` = 1 puts source i in the high level. An eligible high request raises `irq_out` while a low-level routine is in service. No request is offered while a high-level routine is in service.
- R4: A request at the low level is not offered while a low-level routine is in service.
- R5: Within one level, the pending request that wins is the lowest index in the order external 0, timer 0, external 1, timer 1, serial. A pending high request beats any low request.
- R6: While `irq_out` is 1, `vec_addr` equals 16'h0003 + 8 × index (0003, 000B, 0013, 001B, 0023). While `irq_out` is 0, `vec_addr` is 16'h0000.
- R7: A pulse on `tmr_ovf[k]` latches the flag for timer k. The flag clears when the CPU acknowledges that timer's vector.
- R8: With `ext_edge_mode[k]` = 1, a 1-to-0 transition on `ext_pin_n[k]` latches a request that survives the pin returning high. The request clears when its vector is acknowledged.
- R9: With `ext_edge_mode[k]` = 0, the external k request is the inverse of `ext_pin_n[k]` and is not latched.
- R10: The serial request is `ser_rx | ser_tx`. An acknowledge does not clear it.
- R11: A pulse on `ret_strobe` clears the high-level in-service marker if it is set, and otherwise clears the low-level marker.
- R12: `irq_out` and `vec_addr` are registered and reset to 0. When `vec_ack` is sampled while `irq_out` is 1, the offered source is accepted, and `irq_out` is 0 in the next cycle. `irq_out` is also 0 in the cycle after a `ret_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_n | input | 2 | Active-low external interrupt pins |
| ext_edge_mode | input | 2 | Per pin: 1 = falling edge, 0 = low level |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| en_mask | input | 5 | Per-source enables |
| glb_en | input | 1 | Global enable |
| prio_hi | input | 5 | Per-source high-level select |
| vec_ack | input | 1 | CPU acknowledges the offered vector |
| ret_strobe | input | 1 | CPU returns from a service routine |
| irq_out | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 16 | Entry address of the offered source |

## Verification
The bench raises several requests in one cycle at one level, and walks them out one at a time through acknowledge and return. This separates a correct polling order from a reversed one. It also shows that serial keeps requesting after it is acknowledged. Other sequences start a low-level routine and then raise a high request and a second low request. These separate real preemption from simple queuing, and show that a return clears only the upper marker. External pins are driven with short pulses in edge mode and with held levels in level mode. This distinguishes a latched request from one that follows the pin. Global and per-source enable toggles show that the gating applies to flags already pending.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NPAIR   = 2;
  localparam int NSRC    = 2 * NPAIR + 1;
  localparam int IDXW    = $clog2(NSRC);
  localparam int VECW    = 16;
  localparam logic [VECW-1:0] VEC_BASE = 16'h0003;
  localparam int VEC_SHIFT = 3;

  typedef enum logic [IDXW-1:0] {
    SRC_EXT0 = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_EXT1 = 3'd2,
    SRC_TMR1 = 3'd3,
    SRC_SER  = 3'd4
  } src_e;

  function automatic logic [VECW-1:0] vec_of(input logic [IDXW-1:0] idx);
    return VEC_BASE + (VECW'(idx) << VEC_SHIFT);
  endfunction
endpackage

// File: rtl/irq_src_capture.sv
module irq_src_capture
  import irq_pkg::*;
#(
  parameter int NP = NPAIR,
  localparam int NS = 2 * NP + 1,
  localparam int IW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] ext_pin_n,
  input  logic [NP-1:0] ext_edge_mode,
  input  logic [NP-1:0] tmr_ovf,
  input  logic          ser_rx,
  input  logic          ser_tx,
  input  logic          clr_valid,
  input  logic [IW-1:0] clr_idx,
  output logic [NS-1:0] req
);
  for (genvar k = 0; k < NP; k++) begin : g_pair
    localparam int EI = 2 * k;
    localparam int TI = 2 * k + 1;
    logic pin_q, eflag, tflag;
    always_ff @(posedge clk) begin
      if (rst) begin
        pin_q <= 1'b1;
        eflag <= 1'b0;
        tflag <= 1'b0;
      end else begin
        pin_q <= ext_pin_n[k];
        if (!ext_edge_mode[k])
          eflag <= 1'b0;
        else if (pin_q && !ext_pin_n[k])
          eflag <= 1'b1;
        else if (clr_valid && clr_idx == IW'(EI))
          eflag <= 1'b0;
        if (tmr_ovf[k])
          tflag <= 1'b1;
        else if (clr_valid && clr_idx == IW'(TI))
          tflag <= 1'b0;
      end
    end
    assign req[EI] = ext_edge_mode[k] ? eflag : !ext_pin_n[k];
    assign req[TI] = tflag;
  end

  assign req[NS-1] = ser_rx | ser_tx;
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick #(
  parameter int N = 5,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  cand,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic take_hi,
  input  logic ret,
  output logic ins_hi,
  output logic ins_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else if (take) begin
      if (take_hi) ins_hi <= 1'b1;
      else         ins_lo <= 1'b1;
    end else if (ret) begin
      if (ins_hi) ins_hi <= 1'b0;
      else        ins_lo <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NPAIR-1:0] ext_pin_n,
  input  logic [NPAIR-1:0] ext_edge_mode,
  input  logic [NPAIR-1:0] tmr_ovf,
  input  logic            ser_rx,
  input  logic            ser_tx,
  input  logic [NSRC-1:0] en_mask,
  input  logic            glb_en,
  input  logic [NSRC-1:0] prio_hi,
  input  logic            vec_ack,
  input  logic            ret_strobe,
  output logic            irq_out,
  output logic [VECW-1:0] vec_addr
);
  logic [NSRC-1:0] req, elig;
  logic [NSRC-1:0] cand [2];
  logic            found [2];
  logic [IDXW-1:0] pidx [2];
  logic            ins_hi, ins_lo;
  logic            take;
  logic [IDXW-1:0] sel_idx;
  logic            sel_hi;
  logic            win_hi, win_valid;
  logic [IDXW-1:0] win_idx;

  assign take = vec_ack && irq_out;

  irq_src_capture #(.NP(NPAIR)) u_cap (
    .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx),
    .clr_valid(take), .clr_idx(sel_idx), .req(req)
  );

  assign elig    = req & en_mask & {NSRC{glb_en}};
  assign cand[0] = elig & ~prio_hi;
  assign cand[1] = elig & prio_hi;

  for (genvar lv = 0; lv < 2; lv++) begin : g_lvl
    irq_level_pick #(.N(NSRC)) u_pick (
      .cand(cand[lv]), .found(found[lv]), .idx(pidx[lv])
    );
  end

  irq_nest_track u_nest (
    .clk(clk), .rst(rst), .take(take), .take_hi(sel_hi), .ret(ret_strobe),
    .ins_hi(ins_hi), .ins_lo(ins_lo)
  );

  assign win_hi    = found[1] && !ins_hi;
  assign win_valid = win_hi || (found[0] && !ins_hi && !ins_lo);
  assign win_idx   = win_hi ? pidx[1] : pidx[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out  <= 1'b0;
      vec_addr <= '0;
      sel_idx  <= '0;
      sel_hi   <= 1'b0;
    end else if (take || ret_strobe) begin
      irq_out  <= 1'b0;
      vec_addr <= '0;
    end else begin
      irq_out  <= win_valid;
      vec_addr <= win_valid ? vec_of(win_idx) : '0;
      sel_idx  <= win_idx;
      sel_hi   <= win_hi;
    end
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        glb_en,
  input logic        vec_ack,
  input logic        ret_strobe,
  input logic        irq_out,
  input logic [15:0] vec_addr,
  input logic        ins_hi
);
  assert_glb_off_R1: assert property (@(posedge clk) disable iff (rst)
    !glb_en |=> !irq_out);
  assert_vec_align_R6: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (vec_addr[2:0] == 3'd3 && vec_addr <= 16'h0023));
  assert_vec_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !irq_out |-> vec_addr == 16'h0000);
  assert_ack_drop_R12: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && irq_out) |=> !irq_out);
  assert_hi_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    ins_hi |=> !irq_out);
  assert_ret_drop_R11: assert property (@(posedge clk) disable iff (rst)
    ret_strobe |=> !irq_out);
endmodule

bind irq_ctrl_top irq_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .vec_ack(vec_ack),
  .ret_strobe(ret_strobe), .irq_out(irq_out), .vec_addr(vec_addr),
  .ins_hi(ins_hi)
);

// File: tb/irq_ctrl_top_test.sv
module irq_ctrl_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  ext_pin_n = 2'b11, ext_edge_mode = 2'b11, tmr_ovf = 2'b00;
  logic        ser_rx = 1'b0, ser_tx = 1'b0;
  logic [4:0]  en_mask = 5'h1F, prio_hi = 5'h00;
  logic        glb_en = 1'b1, vec_ack = 1'b0, ret_strobe = 1'b0;
  logic        irq_out;
  logic [15:0] vec_addr;

  int checks = 0, failures = 0;
  string cur_tag = "R12";
  bit done = 1'b0;

  irq_ctrl_top uut (
    .clk(clk), .rst(rst), .ext_pin_n(ext_pin_n), .ext_edge_mode(ext_edge_mode),
    .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx), .en_mask(en_mask),
    .glb_en(glb_en), .prio_hi(prio_hi), .vec_ack(vec_ack),
    .ret_strobe(ret_strobe), .irq_out(irq_out), .vec_addr(vec_addr)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  bit       m_irq, m_hi, m_busy_hi, m_busy_lo;
  int       m_sel;
  bit [15:0] m_vec;
  bit [1:0] m_pin_q, m_eflag, m_tflag;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_irq = 0; m_vec = 0; m_sel = 0; m_hi = 0;
      m_busy_hi = 0; m_busy_lo = 0;
      m_pin_q = 2'b11; m_eflag = 0; m_tflag = 0;
    end else begin
      bit [4:0] rq;
      bit took;
      int pick;
      bit pick_hi;
      rq[0] = ext_edge_mode[0] ? m_eflag[0] : !ext_pin_n[0];
      rq[1] = m_tflag[0];
      rq[2] = ext_edge_mode[1] ? m_eflag[1] : !ext_pin_n[1];
      rq[3] = m_tflag[1];
      rq[4] = ser_rx || ser_tx;
      pick = -1; pick_hi = 0;
      if (glb_en && !m_busy_hi)
        for (int i = 0; i < 5; i++)
          if (pick < 0 && rq[i] && en_mask[i] && prio_hi[i]) begin pick = i; pick_hi = 1; end
      if (pick < 0 && glb_en && !m_busy_hi && !m_busy_lo)
        for (int i = 0; i < 5; i++)
          if (pick < 0 && rq[i] && en_mask[i] && !prio_hi[i]) pick = i;
      took = vec_ack && m_irq;
      for (int k = 0; k < 2; k++) begin
        if (!ext_edge_mode[k]) m_eflag[k] = 0;
        else if (m_pin_q[k] && !ext_pin_n[k]) m_eflag[k] = 1;
        else if (took && m_sel == 2*k) m_eflag[k] = 0;
        if (tmr_ovf[k]) m_tflag[k] = 1;
        else if (took && m_sel == 2*k+1) m_tflag[k] = 0;
      end
      m_pin_q = ext_pin_n;
      if (took) begin
        if (m_hi) m_busy_hi = 1; else m_busy_lo = 1;
      end else if (ret_strobe) begin
        if (m_busy_hi) m_busy_hi = 0; else m_busy_lo = 0;
      end
      if (took || ret_strobe) begin
        m_irq = 0; m_vec = 0;
      end else begin
        m_irq = (pick >= 0);
        m_vec = (pick >= 0) ? 16'(16'h0003 + 8*pick) : 16'h0000;
        if (pick >= 0) begin m_sel = pick; m_hi = pick_hi; end
      end
    end
    #1;
    if (!done) begin
      chk(irq_out === m_irq, cur_tag, {15'd0, irq_out}, {15'd0, m_irq});
      chk(vec_addr === m_vec, cur_tag, vec_addr, m_vec);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input bit ei, input logic [15:0] ev, input string tag);
    chk(irq_out === ei && vec_addr === ev, tag, irq_out ? vec_addr : 16'hFFFF, ei ? ev : 16'hFFFF);
  endtask

  task automatic pulse_ovf(input logic [1:0] m);
    @(negedge clk) tmr_ovf = m;
    @(negedge clk) tmr_ovf = 2'b00;
  endtask

  task automatic do_ack;
    @(negedge clk) vec_ack = 1'b1;
    @(negedge clk) vec_ack = 1'b0;
  endtask

  task automatic do_ret;
    @(negedge clk) ret_strobe = 1'b1;
    @(negedge clk) ret_strobe = 1'b0;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    tick(3);
    @(negedge clk) rst = 1'b0;
    expect_out(0, 16'h0000, "R12");
    // R1: global enable gates a pending timer 0 flag
    cur_tag = "R1";
    glb_en = 1'b0;
    pulse_ovf(2'b01);
    tick(3);
    expect_out(0, 16'h0000, "R1");
    glb_en = 1'b1;
    tick(2);
    expect_out(1, 16'h000B, "R1");
    cur_tag = "R7";
    do_ack();
    expect_out(0, 16'h0000, "R12");
    do_ret();
    tick(2);
    expect_out(0, 16'h0000, "R7");
    // R2: per-source enable on timer 1
    cur_tag = "R2";
    en_mask = 5'b10111;
    pulse_ovf(2'b10);
    tick(3);
    expect_out(0, 16'h0000, "R2");
    en_mask = 5'h1F;
    tick(2);
    expect_out(1, 16'h001B, "R2");
    do_ack(); do_ret(); tick(2);
    // R5: four low requests at once, drained in order
    cur_tag = "R5";
    @(negedge clk) begin tmr_ovf = 2'b11; ser_rx = 1'b1; ext_pin_n[1] = 1'b0; end
    @(negedge clk) tmr_ovf = 2'b00;
    tick(1);
    expect_out(1, 16'h000B, "R5");
    do_ack();
    tick(1);
    expect_out(0, 16'h0000, "R4");
    do_ret(); tick(1);
    expect_out(1, 16'h0013, "R5");
    do_ack(); do_ret(); tick(1);
    expect_out(1, 16'h001B, "R6");
    do_ack(); do_ret(); tick(1);
    expect_out(1, 16'h0023, "R6");
    cur_tag = "R10";
    do_ack(); do_ret(); tick(1);
    expect_out(1, 16'h0023, "R10");
    ser_rx = 1'b0; ext_pin_n[1] = 1'b1;
    tick(2);
    expect_out(0, 16'h0000, "R10");
    // R3 and R11: preemption by a high serial request, then unwinding
    cur_tag = "R3";
    pulse_ovf(2'b10);
    tick(1);
    expect_out(1, 16'h001B, "R3");
    do_ack();
    prio_hi = 5'b10000; ser_tx = 1'b1;
    tick(2);
    expect_out(1, 16'h0023, "R3");
    do_ack();
    pulse_ovf(2'b01);
    tick(2);
    expect_out(0, 16'h0000, "R3");
    cur_tag = "R11";
    ser_tx = 1'b0;
    do_ret(); tick(2);
    expect_out(0, 16'h0000, "R11");
    do_ret(); tick(1);
    expect_out(1, 16'h000B, "R11");
    do_ack(); do_ret(); tick(2);
    // R5: a high request beats a lower-index low request
    cur_tag = "R5";
    prio_hi = 5'b01000;
    pulse_ovf(2'b11);
    tick(1);
    expect_out(1, 16'h001B, "R5");
    do_ack(); tick(2);
    expect_out(0, 16'h0000, "R3");
    do_ret(); tick(1);
    expect_out(1, 16'h000B, "R5");
    do_ack(); do_ret(); tick(2);
    prio_hi = 5'h00;
    // R8: falling edge on external 0 is latched
    cur_tag = "R8";
    @(negedge clk) ext_pin_n[0] = 1'b0;
    @(negedge clk) ext_pin_n[0] = 1'b1;
    tick(2);
    expect_out(1, 16'h0003, "R8");
    do_ack(); do_ret(); tick(2);
    expect_out(0, 16'h0000, "R8");
    // R9: level mode on external 1 follows the pin
    cur_tag = "R9";
    ext_edge_mode[1] = 1'b0;
    @(negedge clk) ext_pin_n[1] = 1'b0;
    tick(2);
    expect_out(1, 16'h0013, "R9");
    ext_pin_n[1] = 1'b1;
    tick(2);
    expect_out(0, 16'h0000, "R9");
    tick(2);
    finish_run();
  end
endmodule